// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is a small 8-bit accumulator machine. It runs a program of eight 4-bit instructions and finishes one instruction on every enabled clock. The program and a four-byte table of constants are both driven from outside as flat read-only buses. The core keeps its own state internally: a four-byte writable scratch memory, the accumulator, a 3-bit program counter and a sticky stop flag. All of this state is visible on debug outputs.

The instruction set has four operations. Constants come only from the external byte table. Sums read their second operand only from the internal scratch memory. Results leave the accumulator only through a store. A stop instruction freezes the core until reset, unless the bypass input turns it into a no-op. Because the program counter wraps, a program with no effective stop repeats without end. A run input pauses the whole machine.

Top module: `acc_cpu_core`

## Requirements
- R1: When `rst_n` is low at a rising edge, the program counter, accumulator, every scratch byte and the stop flag all become zero.
- R2: While `run_en` is low, no clock changes the program counter, accumulator, scratch memory or stop flag.
- R3: Instruction bits [3:2] hold the opcode and bits [1:0] hold a byte address. Opcode 01 copies the constant-table byte at that address into the accumulator.
- R4: Opcode 10 writes the accumulator into the scratch byte at the operand address. The other scratch bytes and the accumulator keep their values.
- R5: Opcode 11 replaces the accumulator with the accumulator plus the scratch byte at the operand address, taken modulo 256.
- R6: Every enabled instruction other than a stop advances the program counter by one, and it wraps from 7 to 0.
- R7: Opcode 00 with `hlt_bypass` low sets the stop flag and leaves the program counter on the stop instruction. Once the flag is set, the core changes no state until reset, even if `hlt_bypass` is raised later.
- R8: Opcode 00 with `hlt_bypass` high changes nothing except advancing the program counter.
- R9: With constant bytes 01, 04, 0A, 00 and the program load 0, store 0, load 1, add 0, store 1, load 2, add 1, store 2, one pass through the program leaves scratch bytes 0 to 2 at 01, 05, 0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Executes one instruction per clock when high; freezes the core when low |
| hlt_bypass | input | 1 | Makes opcode 00 act as a no-op |
| const_tbl | input | 32 | Constant table; byte k is at bits [8k+7:8k] |
| prog | input | 32 | Program; instruction k is at bits [4k+3:4k] |
| pc_o | output | 3 | Program counter |
| acc_o | output | 8 | Accumulator |
| scratch_o | output | 32 | Scratch memory; byte k is at bits [8k+7:8k] |
| halted_o | output | 1 | Stop flag |

## Verification
Assertions check on every cycle the rules that tie one cycle to the next:
- the reset values,
- the freeze when `run_en` is low,
- the step of the program counter,
- the sticky stop,
- the accumulator result of a load or an add,
- the write of a store,
- that the decoder never asks to stop and to step at the same time.

Only the directed scenarios can show that whole programs produce the right values. These cover the sample summing program, modulo-256 wrap of the sum, the counter wrap, and the difference between a stop and a bypassed stop. They also show that raising the bypass after a stop does not release the core.

// File: rtl/acc_cpu_pkg.sv
// Shared opcode encoding for the accumulator core.
// Assumes a 2-bit opcode in the top bits of each instruction.
package acc_cpu_pkg;
    typedef enum logic [1:0] {
        OP_STOP  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_ADD   = 2'b11
    } opcode_e;
endpackage

// File: rtl/acc_cpu_decode.sv
// Instruction decoder: turns one fetched instruction into enables for the
// current cycle. Assumes the opcode sits in the two top bits and that the
// caller passes the current stop flag and run enable.
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int OPND_W = 2
) (
    input  logic [OPND_W+1:0] instr_i,
    input  logic              run_en_i,
    input  logic              halted_i,
    input  logic              hlt_bypass_i,
    output logic              load_o,
    output logic              store_o,
    output logic              add_o,
    output logic              stop_o,
    output logic              step_o,
    output logic [OPND_W-1:0] opnd_o
);
    opcode_e op;
    logic    active;

    assign op     = opcode_e'(instr_i[OPND_W+1 -: 2]);
    assign opnd_o = instr_i[OPND_W-1:0];
    assign active = run_en_i && !halted_i;

    // Decode the opcode into one-cycle enables.
    always_comb begin
        load_o  = 1'b0;
        store_o = 1'b0;
        add_o   = 1'b0;
        stop_o  = 1'b0;
        case (op)
            OP_LOAD:  load_o  = active;
            OP_STORE: store_o = active;
            OP_ADD:   add_o   = active;
            default:  stop_o  = active && !hlt_bypass_i;
        endcase
        step_o = active && !stop_o;
    end

    // Check that stop and step are exclusive and at most one data enable is set.
    always_comb begin
        // R7
        stop_step_excl_chk: assert (!(stop_o && step_o) && $onehot0({load_o, store_o, add_o, stop_o}));
    end
endmodule

// File: rtl/acc_cpu_adder.sv
// Accumulator adder: plain modulo-2^W sum. No carry out; the caller keeps
// the low W bits only.
module acc_cpu_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o
);
    // Add with the result truncated to the operand width.
    always_comb sum_o = a_i + b_i;
endmodule

// File: rtl/acc_cpu_scratch.sv
// Scratch memory: register file with one write port and one combinational
// read port, cleared by synchronous active-low reset. Every byte is also
// exposed on a flat bus.
module acc_cpu_scratch #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [DEPTH*DATA_W-1:0] flat_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    // Clear every byte on reset, otherwise write the addressed byte.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n)
                cell_q[k] <= '0;
            else if (wr_en_i && (waddr_i == ADDR_W'(k)))
                cell_q[k] <= wdata_i;
        end
    end

    assign rdata_o = cell_q[raddr_i];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat_o[g*DATA_W +: DATA_W] = cell_q[g];
    end

    // R4
    store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> cell_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/acc_cpu_core.sv
// Accumulator core top. Executes one instruction per enabled clock from an
// external program bus and loads constants from an external byte table.
// Keeps the PC, the accumulator, the stop flag and the scratch memory.
// Assumes both external buses are stable around the clock edge.
module acc_cpu_core #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int PC_W   = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                run_en,
    input  logic                                hlt_bypass,
    input  logic [(1<<ADDR_W)*DATA_W-1:0]       const_tbl,
    input  logic [(1<<PC_W)*(ADDR_W+2)-1:0]     prog,
    output logic [PC_W-1:0]                     pc_o,
    output logic [DATA_W-1:0]                   acc_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0]       scratch_o,
    output logic                                halted_o
);
    localparam int INSTR_W = ADDR_W + 2;

    logic [PC_W-1:0]    pc_q;
    logic [DATA_W-1:0]  acc_q;
    logic               halted_q;
    logic [INSTR_W-1:0] instr;
    logic [ADDR_W-1:0]  opnd;
    logic               load, store, add, stop, step;
    logic [DATA_W-1:0]  const_byte, scr_rd, sum;

    // Fetch the instruction at the PC and the constant at the operand.
    assign instr      = prog[pc_q*INSTR_W +: INSTR_W];
    assign const_byte = const_tbl[opnd*DATA_W +: DATA_W];

    acc_cpu_decode #(.OPND_W(ADDR_W)) dec_i (
        .instr_i(instr), .run_en_i(run_en), .halted_i(halted_q),
        .hlt_bypass_i(hlt_bypass), .load_o(load), .store_o(store),
        .add_o(add), .stop_o(stop), .step_o(step), .opnd_o(opnd)
    );

    acc_cpu_adder #(.DATA_W(DATA_W)) add_i (
        .a_i(acc_q), .b_i(scr_rd), .sum_o(sum)
    );

    acc_cpu_scratch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) scr_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(store), .waddr_i(opnd),
        .wdata_i(acc_q), .raddr_i(opnd), .rdata_o(scr_rd), .flat_o(scratch_o)
    );

    // Update the PC, the stop flag and the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            acc_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            if (step) pc_q <= pc_q + 1'b1;
            if (stop) halted_q <= 1'b1;
            if (load)      acc_q <= const_byte;
            else if (add)  acc_q <= sum;
        end
    end

    assign pc_o     = pc_q;
    assign acc_o    = acc_q;
    assign halted_o = halted_q;

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pc_q == '0 && acc_q == '0 && !halted_q && scratch_o == '0));
    // R2
    run_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(pc_q) && $stable(acc_q) && $stable(halted_q) && $stable(scratch_o)));
    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> acc_q == $past(const_byte));
    // R5
    add_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add |=> acc_q == DATA_W'($past(acc_q) + $past(scr_rd)));
    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> pc_q == PC_W'($past(pc_q) + 1'b1));
    // R7
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (halted_q && $stable(pc_q) && $stable(acc_q) && $stable(scratch_o)));
endmodule

// File: tb/acc_cpu_core_tb_top.sv
// Directed bench for acc_cpu_core; one task per scenario.
module acc_cpu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        hlt_bypass = 1'b0;
    logic [31:0] const_tbl = '0;
    logic [31:0] prog = '0;
    logic [2:0]  pc_o;
    logic [7:0]  acc_o;
    logic [31:0] scratch_o;
    logic        halted_o;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    acc_cpu_core dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .hlt_bypass(hlt_bypass),
        .const_tbl(const_tbl), .prog(prog), .pc_o(pc_o), .acc_o(acc_o),
        .scratch_o(scratch_o), .halted_o(halted_o)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic steps(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic set_prog(input logic [3:0] i0, i1, i2, i3, i4, i5, i6, i7);
        prog = {i7, i6, i5, i4, i3, i2, i1, i0};
    endtask

    function automatic int scr(input int k);
        return int'(scratch_o[k*8 +: 8]);
    endfunction

    // R1: dirty the state, then reset clears everything.
    task automatic t_reset();
        const_tbl = 32'h00_00_00_5A;
        set_prog(4'b0100, 4'b1000, 4'b1011, 4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0100);
        hlt_bypass = 1'b0;
        run_en = 1'b1;
        do_reset();
        steps(3);
        do_reset();
        chk("R1 pc", pc_o, 0);
        chk("R1 acc", acc_o, 0);
        chk("R1 scratch", int'(scratch_o), 0);
        chk("R1 halted", halted_o, 0);
    endtask

    // R9: sample summing program, plus load/add/wrap on the way.
    task automatic t_example();
        const_tbl = {8'h00, 8'h0A, 8'h04, 8'h01};
        set_prog(4'b0100, 4'b1000, 4'b0101, 4'b1100, 4'b1001, 4'b0110, 4'b1101, 4'b1010);
        run_en = 1'b1;
        do_reset();
        steps(1);
        chk("R3 first load", acc_o, 8'h01);
        steps(7);
        chk("R9 scratch0", scr(0), 8'h01);
        chk("R9 scratch1", scr(1), 8'h05);
        chk("R9 scratch2", scr(2), 8'h0F);
        chk("R4 scratch3 untouched", scr(3), 0);
        chk("R5 sum in acc", acc_o, 8'h0F);
        chk("R6 pc wrapped", pc_o, 0);
    endtask

    // R3 and R6: each address loads its own byte, PC steps by one.
    task automatic t_load_each();
        const_tbl = {8'h44, 8'h33, 8'h22, 8'h11};
        set_prog(4'b0111, 4'b0110, 4'b0101, 4'b0100, 4'b0111, 4'b0110, 4'b0101, 4'b0100);
        run_en = 1'b1;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            steps(1);
            chk("R3 load", acc_o, 8'h44 - 8'h11 * (i % 4));
            chk("R6 pc", pc_o, (i + 1) % 8);
        end
    endtask

    // R4, R5, R7: modulo-256 sum, store isolation, then a stop.
    task automatic t_add_wrap();
        const_tbl = {8'h00, 8'h00, 8'h00, 8'hFF};
        set_prog(4'b0100, 4'b1001, 4'b1101, 4'b1010, 4'b0000, 4'b0100, 4'b0100, 4'b0100);
        hlt_bypass = 1'b0;
        run_en = 1'b1;
        do_reset();
        steps(4);
        chk("R5 wrap sum", acc_o, 8'hFE);
        chk("R4 scratch1", scr(1), 8'hFF);
        chk("R4 scratch2", scr(2), 8'hFE);
        chk("R4 scratch0 kept", scr(0), 0);
        chk("R4 scratch3 kept", scr(3), 0);
        chk("R6 pc", pc_o, 4);
        steps(1);
        chk("R7 halted", halted_o, 1);
        chk("R7 pc held", pc_o, 4);
    endtask

    // R2: run low freezes all state.
    task automatic t_freeze();
        const_tbl = {8'h00, 8'h00, 8'h09, 8'h07};
        set_prog(4'b0100, 4'b1000, 4'b0101, 4'b1100, 4'b0100, 4'b0100, 4'b0100, 4'b0100);
        run_en = 1'b1;
        do_reset();
        steps(2);
        run_en = 1'b0;
        steps(5);
        chk("R2 pc", pc_o, 2);
        chk("R2 acc", acc_o, 8'h07);
        chk("R2 scratch0", scr(0), 8'h07);
        run_en = 1'b1;
        steps(2);
        chk("R2 resume acc", acc_o, 8'h10);
    endtask

    // R7 and R1: stop is sticky, ignores later bypass, reset releases it.
    task automatic t_stop();
        const_tbl = {8'h00, 8'h00, 8'h66, 8'h55};
        set_prog(4'b0100, 4'b0000, 4'b0101, 4'b1000, 4'b0100, 4'b0100, 4'b0100, 4'b0100);
        hlt_bypass = 1'b0;
        run_en = 1'b1;
        do_reset();
        steps(2);
        chk("R7 halted", halted_o, 1);
        chk("R7 pc on stop", pc_o, 1);
        steps(3);
        hlt_bypass = 1'b1;
        steps(3);
        chk("R7 still halted", halted_o, 1);
        chk("R7 pc kept", pc_o, 1);
        chk("R7 acc kept", acc_o, 8'h55);
        chk("R7 scratch kept", scr(0), 0);
        do_reset();
        chk("R1 halted cleared", halted_o, 0);
    endtask

    // R8: bypassed stop is a no-op that advances the PC.
    task automatic t_bypass();
        const_tbl = {8'h00, 8'h00, 8'h66, 8'h55};
        set_prog(4'b0100, 4'b0000, 4'b0101, 4'b1000, 4'b0100, 4'b0100, 4'b0100, 4'b0100);
        hlt_bypass = 1'b1;
        run_en = 1'b1;
        do_reset();
        steps(2);
        chk("R8 not halted", halted_o, 0);
        chk("R8 pc advanced", pc_o, 2);
        chk("R8 acc kept", acc_o, 8'h55);
        steps(1);
        chk("R8 continues", acc_o, 8'h66);
    endtask

    initial begin
        t_reset();
        t_example();
        t_load_each();
        t_add_wrap();
        t_freeze();
        t_stop();
        t_bypass();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule